// File: doc/BRIEF.md
# Polling Register-Read Sequencer

This block is the host side of a slow five-wire register link. It drives a 5-bit select bus to a remote responder and samples a 5-bit answer bus. It walks through the responder's registers 1 to 14 in order. Each answer carries a 4-bit data nibble and an odd-parity bit. The nibbles are collected into a small file of result words. Before every register read, the sequencer drives select 0 and waits until the responder answers with all zeros. This proves the link is alive and the answer bus has returned to idle.

After the idle check, the sequencer drives the register number. It holds that number for a settle time set in clock cycles, then takes a single sample of the answer bus. A sample with good parity is written into one half of a destination word, and the sequencer moves on to the next register. A sample with bad parity is thrown away and counted, and the same register is read again from the idle check. A one-hot strobe marks each word that has just been updated. A combinational read port gives the contents of any word.

Top module: `pollrd_master`

## Requirements
- R1: While the sequencer is in the idle-check step it drives select 0. It leaves that step only in the cycle after the answer bus reads all zeros. Any nonzero answer keeps select at 0.
- R2: In the read step the select bus carries the current register number for exactly SETTLE_CYC consecutive cycles. The answer bus is sampled only at the end of the last of those cycles. The settle count starts again from zero each time the read step is entered.
- R3: A sample is accepted only when its five bits hold an odd number of ones. Bit 4 is the parity bit and bits 3..0 are the data. A rejected sample writes no word and raises no strobe. It leaves the register number unchanged, adds one to the error counter (which wraps at 2^ERR_W) and sends the sequencer back to the idle-check step.
- R4: A register r is stored in the word whose absolute index is (r >> 1) + 9. The read port returns 0 for any index outside 9..16.
- R5: An even register writes its nibble into bits 3..0 of the destination word and keeps bits 7..4. An odd register writes bits 7..4 and keeps bits 3..0. Bits 15..8 are always 0.
- R6: After an accepted sample the register number steps up by one. After register 14 it goes back to 1, and it is 1 after reset. It never leaves the range 1..14.
- R7: One clock after an accepted sample, upd_o has exactly one bit set for one cycle: bit k for word 9+k. In that same cycle the read port already shows the new word. At every other time upd_o is 0.
- R8: After reset, select is 0, upd_o is 0, the error counter is 0 and every word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rsp_i | input | 5 | Answer bus from the responder (bit 4 parity, bits 3..0 data) |
| sel_o | output | 5 | Register select driven to the responder |
| upd_o | output | 8 | One-cycle update strobe, bit k for word 9+k |
| rd_idx_i | input | 5 | Absolute word index for the read port |
| rd_word_o | output | 16 | Contents of the indexed word, 0 when out of range |
| perr_cnt_o | output | 8 | Count of rejected samples |

## Verification
The responder model answers the idle check with random-length runs of nonzero values. This tells a sequencer that waits for a true zero apart from one that proceeds at once. During the read step the model drives junk on every cycle except the last settle cycle, so sampling one cycle early or late corrupts the data and shows up as a mismatch. Random nibbles are sent with good or deliberately broken parity, and the all-zero and all-one nibbles are forced. These cases separate accepting a sample from discarding it, low-half writes from high-half writes, and advancing the register from holding it. A forced parity failure on register 14 and several full passes through 1..14 exercise the wrap back to register 1 and the words 9 and 16, which only ever get one half written.

// File: rtl/pollrd_pkg.sv
package pollrd_pkg;

    typedef enum logic {
        ST_LINK = 1'b0,
        ST_READ = 1'b1
    } step_e;

endpackage

// File: rtl/pollrd_parity.sv
module pollrd_parity #(
    parameter int W = 5
) (
    input  logic [W-1:0] vec_i,
    output logic         odd_o
);

    always_comb begin
        odd_o = ^vec_i;
    end

endmodule

// File: rtl/pollrd_settle_timer.sv
module pollrd_settle_timer #(
    parameter int SETTLE_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic done_o
);

    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        done_o = (cnt_q == LAST_CNT);
        cnt_d  = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (!done_o) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    p_restart_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0));

    p_counts_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && !done_o) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/pollrd_word_file.sv
module pollrd_word_file #(
    parameter int NWORDS = 8,
    parameter int WORD_W = 16,
    parameter int NIB_W  = 4,
    parameter int IDX_W  = 5,
    parameter int IDX_LO = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [$clog2(NWORDS)-1:0] wr_slot_i,
    input  logic                      wr_hi_i,
    input  logic [NIB_W-1:0]          wr_nib_i,
    input  logic [IDX_W-1:0]          rd_idx_i,
    output logic [WORD_W-1:0]         rd_word_o,
    output logic [NWORDS-1:0]         upd_o
);

    localparam int SLOT_W = $clog2(NWORDS);

    logic [WORD_W-1:0] word_d [NWORDS];
    logic [WORD_W-1:0] word_q [NWORDS];
    logic [NWORDS-1:0] upd_d, upd_q;
    logic [NWORDS-1:0] hit;

    for (genvar k = 0; k < NWORDS; k++) begin : g_word
        always_comb begin
            hit[k]    = wr_en_i && (wr_slot_i == SLOT_W'(k));
            upd_d[k]  = hit[k];
            word_d[k] = word_q[k];
            if (hit[k]) begin
                if (wr_hi_i) begin
                    word_d[k][2*NIB_W-1:NIB_W] = wr_nib_i;
                end else begin
                    word_d[k][NIB_W-1:0] = wr_nib_i;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[k] <= '0;
            end else begin
                word_q[k] <= word_d[k];
            end
        end

        p_word_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !hit[k] |=> $stable(word_q[k]));

        p_half_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[k] && wr_hi_i) |=> (word_q[k][NIB_W-1:0] == $past(word_q[k][NIB_W-1:0])));

        if (WORD_W > 2 * NIB_W) begin : g_upper
            p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
                word_q[k][WORD_W-1:2*NIB_W] == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_q <= '0;
        end else begin
            upd_q <= upd_d;
        end
    end

    logic [IDX_W-1:0] rel;

    always_comb begin
        rel       = rd_idx_i - IDX_W'(IDX_LO);
        rd_word_o = '0;
        if (rel < IDX_W'(NWORDS)) begin
            rd_word_o = word_q[rel[SLOT_W-1:0]];
        end
        upd_o = upd_q;
    end

    p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd_q));

    p_strobe_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_q != '0) |=> (upd_q != $past(upd_q)));

endmodule

// File: rtl/pollrd_master.sv
module pollrd_master
    import pollrd_pkg::*;
#(
    parameter int SEL_W      = 5,
    parameter int FIRST_REG  = 1,
    parameter int LAST_REG   = 14,
    parameter int IDX_BASE   = 9,
    parameter int WORD_W     = 16,
    parameter int SETTLE_CYC = 2000,
    parameter int ERR_W      = 8
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic [SEL_W-1:0]                           rsp_i,
    output logic [SEL_W-1:0]                           sel_o,
    output logic [(LAST_REG>>1)-(FIRST_REG>>1):0]      upd_o,
    input  logic [SEL_W-1:0]                           rd_idx_i,
    output logic [WORD_W-1:0]                          rd_word_o,
    output logic [ERR_W-1:0]                           perr_cnt_o
);

    localparam int NIB_W  = SEL_W - 1;
    localparam int NWORDS = (LAST_REG >> 1) - (FIRST_REG >> 1) + 1;
    localparam int SLOT_W = $clog2(NWORDS);
    localparam int IDX_LO = IDX_BASE + (FIRST_REG >> 1);
    localparam logic [SEL_W-1:0] REG_LO = SEL_W'(FIRST_REG);
    localparam logic [SEL_W-1:0] REG_HI = SEL_W'(LAST_REG);

    typedef struct packed {
        step_e             step;
        logic [SEL_W-1:0]  reg_n;
        logic [ERR_W-1:0]  errs;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              settled;
    logic              restart;
    logic              odd;
    logic              wr_en;
    logic [SLOT_W-1:0] wr_slot;

    pollrd_parity #(.W(SEL_W)) u_par (
        .vec_i (rsp_i),
        .odd_o (odd)
    );

    pollrd_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .done_o    (settled)
    );

    always_comb begin
        ctl_d   = ctl_q;
        restart = 1'b0;
        wr_en   = 1'b0;
        wr_slot = SLOT_W'((ctl_q.reg_n >> 1) - SEL_W'(FIRST_REG >> 1));

        if (ctl_q.reg_n < REG_LO || ctl_q.reg_n > REG_HI) begin
            ctl_d.reg_n = REG_LO;
        end

        unique case (ctl_q.step)
            ST_LINK: begin
                if (rsp_i == '0) begin
                    ctl_d.step = ST_READ;
                    restart    = 1'b1;
                end
            end
            ST_READ: begin
                if (settled) begin
                    ctl_d.step = ST_LINK;
                    if (odd) begin
                        wr_en       = 1'b1;
                        ctl_d.reg_n = (ctl_q.reg_n >= REG_HI) ? REG_LO
                                                              : ctl_q.reg_n + SEL_W'(1);
                    end else begin
                        ctl_d.errs = ctl_q.errs + ERR_W'(1);
                    end
                end
            end
            default: ctl_d.step = ST_LINK;
        endcase

        sel_o      = (ctl_q.step == ST_READ) ? ctl_q.reg_n : '0;
        perr_cnt_o = ctl_q.errs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.step  <= ST_LINK;
            ctl_q.reg_n <= REG_LO;
            ctl_q.errs  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pollrd_word_file #(
        .NWORDS (NWORDS),
        .WORD_W (WORD_W),
        .NIB_W  (NIB_W),
        .IDX_W  (SEL_W),
        .IDX_LO (IDX_LO)
    ) u_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_slot_i (wr_slot),
        .wr_hi_i   (ctl_q.reg_n[0]),
        .wr_nib_i  (rsp_i[NIB_W-1:0]),
        .rd_idx_i  (rd_idx_i),
        .rd_word_o (rd_word_o),
        .upd_o     (upd_o)
    );

    p_link_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.step == ST_LINK && rsp_i != '0) |=> (sel_o == '0));

    p_link_go_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.step == ST_LINK && rsp_i == '0) |=> (sel_o != '0));

    p_wait_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.step == ST_READ && !settled) |=> (sel_o == $past(sel_o)));

    p_bad_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.step == ST_READ && settled && !odd)
        |=> ($stable(ctl_q.reg_n) && upd_o == '0 && sel_o == '0));

    p_good_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.step == ST_READ && settled && odd) |=> (upd_o != '0));

    p_reg_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.reg_n >= REG_LO && ctl_q.reg_n <= REG_HI));

endmodule

// File: tb/tb_pollrd_master.sv
`timescale 1ns/1ps
module tb_pollrd_master;

    localparam int SETTLE = 6;
    localparam int ATTEMPTS = 90;
    localparam int CYC_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rsp_i = 5'd0;
    logic [4:0]  sel_o;
    logic [7:0]  upd_o;
    logic [4:0]  rd_idx_i = 5'd0;
    logic [15:0] rd_word_o;
    logic [7:0]  perr_cnt_o;

    always #2.5 clk = ~clk;

    pollrd_master #(.SETTLE_CYC(SETTLE)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rsp_i      (rsp_i),
        .sel_o      (sel_o),
        .upd_o      (upd_o),
        .rd_idx_i   (rd_idx_i),
        .rd_word_o  (rd_word_o),
        .perr_cnt_o (perr_cnt_o)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] make_rsp(input logic [3:0] nib, input bit good);
        logic p;
        p = good ? ~(^nib) : (^nib);
        return {p, nib};
    endfunction

    function automatic logic [4:0] next_reg(input logic [4:0] r);
        return (r == 5'd14) ? 5'd1 : r + 5'd1;
    endfunction

    logic [15:0] mdl [32];

    initial begin
        logic [4:0] exp_reg;
        logic [4:0] prev_sel;
        logic [4:0] last_drive;
        logic [4:0] s;
        logic [4:0] idx;
        logic [3:0] att_nib;
        bit         att_good;
        bit         forced14;
        bit         wd;
        int         run_len;
        int         stall;
        int         attempts;
        int         exp_err;
        int         cyc;

        void'($urandom(32'd1977));
        for (int i = 0; i < 32; i++) mdl[i] = 16'h0;
        exp_reg = 5'd1; prev_sel = 5'd0; last_drive = 5'h1F;
        att_nib = 4'h0; att_good = 1'b1; forced14 = 1'b0; wd = 1'b0;
        run_len = 0; stall = 0; attempts = 0; exp_err = 0; cyc = 0;

        repeat (3) @(negedge clk);
        // R8: reset state
        chk(sel_o == 5'd0, "R8", "select in reset", sel_o, 0);
        chk(upd_o == 8'd0, "R8", "strobe in reset", upd_o, 0);
        chk(perr_cnt_o == 8'd0, "R8", "error count in reset", perr_cnt_o, 0);
        for (int i = 9; i <= 16; i++) begin
            rd_idx_i = 5'(i);
            #0.2;
            chk(rd_word_o == 16'h0, "R8", "word in reset", rd_word_o, 0);
        end
        rsp_i = 5'h13;   // nonzero answer at release: idle check must hold
        last_drive = 5'h13;
        rst_n = 1'b1;

        while (attempts < ATTEMPTS) begin
            @(negedge clk);
            cyc++;
            if (cyc > CYC_LIMIT) begin
                wd = 1'b1;
                break;
            end
            s = sel_o;

            if (prev_sel != 5'd0 && s == 5'd0) begin
                // R2: held for exactly SETTLE cycles
                chk(run_len == SETTLE, "R2", "settle length", run_len, SETTLE);
                if (att_good) begin
                    idx = (exp_reg >> 1) + 5'd9;
                    if (exp_reg[0]) mdl[idx][7:4] = att_nib;
                    else            mdl[idx][3:0] = att_nib;
                    chk(upd_o != 8'd0 && $onehot(upd_o), "R7", "strobe after accept", upd_o, 1);
                    chk(upd_o == 8'(1 << (exp_reg >> 1)), "R4", "strobe word position",
                        upd_o, 8'(1 << (exp_reg >> 1)));
                    rd_idx_i = idx;
                    #0.2;
                    chk(rd_word_o == mdl[idx], "R5", "word contents", rd_word_o, mdl[idx]);
                    chk(perr_cnt_o == 8'(exp_err), "R3", "error count after accept",
                        perr_cnt_o, exp_err);
                    exp_reg = next_reg(exp_reg);
                end else begin
                    exp_err++;
                    chk(upd_o == 8'd0, "R3", "no strobe on bad parity", upd_o, 0);
                    chk(perr_cnt_o == 8'(exp_err), "R3", "error count after reject",
                        perr_cnt_o, exp_err);
                end
                attempts++;
                stall = int'($urandom % 4);
            end else begin
                chk(upd_o == 8'd0, "R7", "strobe outside accept", upd_o, 0);
            end

            if (prev_sel == 5'd0 && s != 5'd0) begin
                chk(last_drive == 5'd0, "R1", "left idle check on nonzero answer", last_drive, 0);
                chk(s == exp_reg, "R6", "register number", s, exp_reg);
                run_len = 0;
                att_nib = 4'($urandom);
                att_good = ($urandom % 4) != 0;
                if (attempts == 1) begin att_nib = 4'h0; att_good = 1'b1; end
                if (attempts == 2) begin att_nib = 4'hF; att_good = 1'b1; end
                if (exp_reg == 5'd14 && !forced14) begin
                    att_good = 1'b0;
                    forced14 = 1'b1;
                end
            end else if (prev_sel == 5'd0 && s == 5'd0 && last_drive == 5'd0) begin
                chk(1'b0, "R1", "stayed in idle check after zero answer", s, exp_reg);
            end else if (prev_sel != 5'd0 && s != 5'd0) begin
                chk(s == prev_sel, "R2", "select stable while settling", s, prev_sel);
            end

            if (s == 5'd0) begin
                if (stall > 0) begin
                    rsp_i = 5'd1 + 5'($urandom % 31);
                    stall--;
                end else begin
                    rsp_i = 5'd0;
                end
                last_drive = rsp_i;
            end else begin
                run_len++;
                if (run_len == SETTLE) rsp_i = make_rsp(att_nib, att_good);
                else                   rsp_i = 5'($urandom);
            end
            prev_sel = s;
        end

        if (wd) begin
            chk(1'b0, "R1", "watchdog expired", cyc, CYC_LIMIT);
        end else begin
            // R4: out-of-range indices read as zero; R6: wrapped at least once
            rd_idx_i = 5'd8;
            #0.2;
            chk(rd_word_o == 16'h0, "R4", "index below range", rd_word_o, 0);
            rd_idx_i = 5'd17;
            #0.2;
            chk(rd_word_o == 16'h0, "R4", "index above range", rd_word_o, 0);
            chk(forced14, "R6", "register 14 reached", int'(forced14), 1);
            for (int i = 9; i <= 16; i++) begin
                rd_idx_i = 5'(i);
                #0.2;
                chk(rd_word_o == mdl[i], "R5", "final word contents", rd_word_o, mdl[i]);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule